// File: doc/BRIEF.md
# Integer-N Synthesizer Divider Core with Phase/Frequency Detector

This block is the digital core of an integer-N frequency synthesizer. It runs on one system clock and receives two event strobes: one marks each edge of the VCO signal and one marks each edge of the reference oscillator. Feedback events pass through a fixed prescaler and then a programmable divider whose ratio comes from a 4-bit code. Reference events pass through their own fixed prescaler and a one-cycle retiming stage. The retiming stage gives both paths the same latency. A phase/frequency detector compares the two divided edges. It reports pump-up, pump-down or off, and it drives an output-enable that is low whenever the pump should float.

Two test outputs change level once per divided edge, so each shows its chain at half the detector-input rate. An active-high reset clears both prescalers, the divider and the detector. While reset is high, the pump is forced off without waiting for a clock edge.

With the default parameters, code k gives an overall feedback division of 8 × (25 + k) VCO events, so the loop covers multiplication factors from 200 to 320 times the reference division.

Top module: `synth_divpfd`

## Requirements
- R1: `ref_test` changes level once for every 8 reference events.
- R2: With `ratio_code` = k (bit 0 is the LSB, bit 3 the MSB), `fb_test` changes level once for every 8 × (25 + k) VCO events, so code 0 gives 200 and code 15 gives 320.
- R3: A change on `ratio_code` is used only from the next divider terminal count. The divider period that is already running keeps the ratio that was loaded when it started.
- R4: A divided reference edge that arrives before the divided feedback edge gives `pump_up` = 1 and `pump_oe` = 1 until the feedback edge arrives.
- R5: A divided feedback edge that arrives before the divided reference edge gives `pump_dn` = 1 and `pump_oe` = 1. `pump_dn` rises on the same clock edge on which `fb_test` changes level.
- R6: Divided edges that arrive in the same cycle produce no pump activity (`pump_oe` stays 0). Both detector flags then clear on the next clock.
- R7: While `rst` = 1, `pump_oe`, `pump_up` and `pump_dn` are 0 at once. The prescalers restart from zero, so after release with continuous reference events the first `ref_test` change comes on the 9th clock edge.
- R8: `pump_up` and `pump_dn` are never 1 together, and `pump_oe` is 1 exactly when one of them is 1.
- R9: A lead of N cycles between divided edges gives N cycles of pump activity per compare period, in the direction of the edge that led.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high synchronous reset; it also gates the pump outputs off combinationally |
| vco_pulse | input | 1 | One-cycle strobe for each VCO edge |
| osc_pulse | input | 1 | One-cycle strobe for each reference oscillator edge |
| ratio_code | input | 4 | Divide-ratio code k; the ratio is 25 + k |
| pump_up | output | 1 | Pump source (up) request |
| pump_dn | output | 1 | Pump sink (down) request |
| pump_oe | output | 1 | Pump drive enable; 0 means high impedance |
| fb_test | output | 1 | Changes level on each programmable-divider output |
| ref_test | output | 1 | Changes level on each divided reference edge |

## Verification
The bench sweeps all sixteen codes and measures the spacing between `fb_test` changes. A ratio offset, a code bit taken in the wrong order, or a terminal count off by one would show up as a wrong gap. It changes the code just after a terminal count. A divider that reloaded at once would produce a 320-cycle gap where a 200-cycle gap is expected.

It places the reference edge exactly on the feedback edge, then 3 cycles ahead of it, then 3 cycles behind it. A retiming stage that is missing or doubled would show as pump activity on aligned edges. A detector that failed to clear would show as pulse widths other than 3 cycles per period. It also raises reset while the pump is active and checks the first reference toggle after release. An enable that waited for a clock edge, or a prescaler that was not cleared, would be caught there.

// File: rtl/synth_pkg.sv
package synth_pkg;
   typedef enum logic [1:0] {
      PUMP_OFF = 2'd0,
      PUMP_UP  = 2'd1,
      PUMP_DN  = 2'd2
   } pump_e;

   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/event_prescaler.sv
module event_prescaler #(
   parameter int unsigned DIV = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic ev,
   output logic tc_pulse
);
   localparam int unsigned CW = synth_pkg::cnt_width(DIV - 1);
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);
   localparam bit POW2 = ((DIV & (DIV - 1)) == 0);

   if (DIV < 2) begin : g_bad_div
      $error("event_prescaler: DIV must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic          at_last;

   assign at_last = (cnt_q == LAST);

   if (POW2) begin : g_wrap
      always_ff @(posedge clk) begin
         if (rst) begin
            cnt_q <= '0;
         end else if (ev) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end else begin : g_cmp
      always_ff @(posedge clk) begin
         if (rst) begin
            cnt_q <= '0;
         end else if (ev) begin
            cnt_q <= at_last ? '0 : cnt_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         tc_pulse <= 1'b0;
      end else begin
         tc_pulse <= ev && at_last;
      end
   end
endmodule

// File: rtl/prog_divider.sv
module prog_divider #(
   parameter int unsigned CODE_W = 4,
   parameter int unsigned BASE   = 25
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_pulse,
   input  logic [CODE_W-1:0] code,
   output logic              out_pulse
);
   localparam int unsigned MAX_RATIO = BASE + (1 << CODE_W) - 1;
   localparam int unsigned CW = synth_pkg::cnt_width(MAX_RATIO);

   if (BASE < 1) begin : g_bad_base
      $error("prog_divider: BASE must be at least 1");
   end
   if (CODE_W < 1 || CODE_W > 8) begin : g_bad_code
      $error("prog_divider: CODE_W must be 1..8");
   end

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] lim_q;
   logic [CW-1:0] lim_new;
   logic          at_lim;

   assign lim_new = CW'(BASE - 1) + CW'(code);
   assign at_lim  = (cnt_q == lim_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q     <= '0;
         lim_q     <= lim_new;
         out_pulse <= 1'b0;
      end else begin
         out_pulse <= in_pulse && at_lim;
         if (in_pulse) begin
            if (at_lim) begin
               cnt_q <= '0;
               lim_q <= lim_new;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/pfd_core.sv
module pfd_core (
   input  logic               clk,
   input  logic               rst,
   input  logic               ref_ev,
   input  logic               fb_ev,
   output synth_pkg::pump_e   state
);
   import synth_pkg::*;

   logic up_q, dn_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         up_q <= 1'b0;
         dn_q <= 1'b0;
      end else if (up_q && dn_q) begin
         up_q <= ref_ev;
         dn_q <= fb_ev;
      end else begin
         up_q <= up_q | ref_ev;
         dn_q <= dn_q | fb_ev;
      end
   end

   always_comb begin
      unique case ({up_q, dn_q})
         2'b10:   state = PUMP_UP;
         2'b01:   state = PUMP_DN;
         default: state = PUMP_OFF;
      endcase
   end
endmodule

// File: rtl/synth_divpfd.sv
module synth_divpfd #(
   parameter int unsigned FB_PRE_DIV  = 8,
   parameter int unsigned REF_PRE_DIV = 8,
   parameter int unsigned CODE_W      = 4,
   parameter int unsigned RATIO_BASE  = 25,
   parameter bit          REF_ALIGN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              vco_pulse,
   input  logic              osc_pulse,
   input  logic [CODE_W-1:0] ratio_code,
   output logic              pump_up,
   output logic              pump_dn,
   output logic              pump_oe,
   output logic              fb_test,
   output logic              ref_test
);
   import synth_pkg::*;

   logic  fb_pre_tc, fb_div_tc;
   logic  ref_pre_tc, ref_edge;
   pump_e pfd_state;

   event_prescaler #(.DIV(FB_PRE_DIV)) u_fb_pre (
      .clk(clk), .rst(rst), .ev(vco_pulse), .tc_pulse(fb_pre_tc)
   );

   prog_divider #(.CODE_W(CODE_W), .BASE(RATIO_BASE)) u_fb_div (
      .clk(clk), .rst(rst), .in_pulse(fb_pre_tc),
      .code(ratio_code), .out_pulse(fb_div_tc)
   );

   event_prescaler #(.DIV(REF_PRE_DIV)) u_ref_pre (
      .clk(clk), .rst(rst), .ev(osc_pulse), .tc_pulse(ref_pre_tc)
   );

   if (REF_ALIGN) begin : g_ref_retime
      logic ref_dly_q;
      always_ff @(posedge clk) begin
         if (rst) ref_dly_q <= 1'b0;
         else     ref_dly_q <= ref_pre_tc;
      end
      assign ref_edge = ref_dly_q;
   end else begin : g_ref_direct
      assign ref_edge = ref_pre_tc;
   end

   pfd_core u_pfd (
      .clk(clk), .rst(rst), .ref_ev(ref_edge), .fb_ev(fb_div_tc),
      .state(pfd_state)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         fb_test  <= 1'b0;
         ref_test <= 1'b0;
      end else begin
         if (fb_div_tc)  fb_test  <= ~fb_test;
         if (ref_pre_tc) ref_test <= ~ref_test;
      end
   end

   assign pump_up = (pfd_state == PUMP_UP) && !rst;
   assign pump_dn = (pfd_state == PUMP_DN) && !rst;
   assign pump_oe = pump_up || pump_dn;
endmodule

// File: rtl/synth_divpfd_chk.sv
module synth_divpfd_chk (
   input logic clk,
   input logic rst,
   input logic pump_up,
   input logic pump_dn,
   input logic pump_oe,
   input logic fb_test,
   input logic ref_test
);
   always_comb begin
      if (rst === 1'b1) begin
         p_off_in_reset_r7: assert (!pump_oe && !pump_up && !pump_dn)
            else $error("pump active during reset");
      end
   end

   p_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
      !(pump_up && pump_dn) && (pump_oe == (pump_up || pump_dn)))
      else $error("pump outputs inconsistent");

   p_dn_on_fb_edge_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(pump_dn) |-> (fb_test != $past(fb_test)))
      else $error("pump_dn rose without feedback edge");

   p_up_after_ref_edge_r4: assert property (@(posedge clk) disable iff (rst)
      $rose(pump_up) |-> ($past(ref_test) != $past(ref_test, 2)))
      else $error("pump_up rose without reference edge");
endmodule

bind synth_divpfd synth_divpfd_chk chk_i (
   .clk(clk), .rst(rst), .pump_up(pump_up), .pump_dn(pump_dn),
   .pump_oe(pump_oe), .fb_test(fb_test), .ref_test(ref_test)
);

// File: tb/synth_divpfd_tb_top.sv
module synth_divpfd_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       vco_pulse = 1'b0;
   logic       osc_pulse = 1'b0;
   logic [3:0] ratio_code = 4'd0;
   logic       pump_up, pump_dn, pump_oe, fb_test, ref_test;

   int n_chk = 0;
   int n_bad = 0;
   int c = 0;
   int gcyc = 0;
   bit vco_en = 0;
   bit osc_en = 0;
   int osc_ph = 1;
   int osc_per = 1;
   logic prev_fb = 1'b0, prev_ref = 1'b0;
   bit fb_tog = 0, ref_tog = 0;
   int up_cnt = 0, dn_cnt = 0;

   always #2 clk = ~clk;

   synth_divpfd dut_i (
      .clk(clk), .rst(rst), .vco_pulse(vco_pulse), .osc_pulse(osc_pulse),
      .ratio_code(ratio_code), .pump_up(pump_up), .pump_dn(pump_dn),
      .pump_oe(pump_oe), .fb_test(fb_test), .ref_test(ref_test)
   );

   always @(posedge clk) begin
      gcyc <= gcyc + 1;
      if (gcyc > 150000) begin
         n_bad = n_bad + 1;
         $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", gcyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic bit osc_at(input int cc);
      return osc_en && cc >= osc_ph && ((cc - osc_ph) % osc_per) == 0;
   endfunction

   task automatic tick();
      @(posedge clk);
      #1;
      c++;
      fb_tog  = (fb_test !== prev_fb);
      ref_tog = (ref_test !== prev_ref);
      prev_fb  = fb_test;
      prev_ref = ref_test;
      if (c >= 250 && c < 850) begin
         if (pump_up) up_cnt++;
         if (pump_dn) dn_cnt++;
      end
      vco_pulse = vco_en;
      osc_pulse = osc_at(c + 1);
   endtask

   task automatic restart(input bit v, input bit o, input int ph, input int per);
      rst = 1'b1;
      vco_en = 0; osc_en = 0;
      vco_pulse = 0; osc_pulse = 0;
      repeat (3) @(posedge clk);
      #1;
      prev_fb = fb_test; prev_ref = ref_test;
      vco_en = v; osc_en = o; osc_ph = ph; osc_per = per;
      c = 0; up_cnt = 0; dn_cnt = 0;
      rst = 1'b0;
      vco_pulse = vco_en;
      osc_pulse = osc_at(1);
   endtask

   task automatic wait_fb(output int at);
      int lim = c + 3000;
      do tick(); while (!fb_tog && c < lim);
      at = c;
   endtask

   task automatic wait_ref(output int at);
      int lim = c + 3000;
      do tick(); while (!ref_tog && c < lim);
      at = c;
   endtask

   initial begin
      int t0, t1, t2;
      repeat (2) @(posedge clk);
      #1;
      // R7: reset state
      check(!pump_oe && !pump_up && !pump_dn, "R7 reset outputs", pump_oe, 0);
      check(fb_test == 0 && ref_test == 0, "R7 reset test outputs", fb_test, 0);

      // R2 / R5: sweep all codes, feedback only
      for (int k = 0; k < 16; k++) begin
         ratio_code = 4'(k);
         restart(1, 0, 1, 1);
         wait_fb(t0);
         check(pump_dn && pump_oe && !pump_up, "R5 dn after fb edge", pump_dn, 1);
         if (k == 0) check(t0 == 202, "R2 first fb edge latency", t0, 202);
         wait_fb(t1);
         wait_fb(t2);
         check(t1 - t0 == 8 * (25 + k), "R2 fb period", t1 - t0, 8 * (25 + k));
         check(t2 - t1 == 8 * (25 + k), "R2 fb period repeat", t2 - t1, 8 * (25 + k));
      end

      // R3: code change mid-period takes effect at next terminal count
      ratio_code = 4'd0;
      restart(1, 0, 1, 1);
      wait_fb(t0);
      ratio_code = 4'd15;
      wait_fb(t1);
      wait_fb(t2);
      check(t1 - t0 == 200, "R3 running period keeps old ratio", t1 - t0, 200);
      check(t2 - t1 == 320, "R3 new ratio after terminal", t2 - t1, 320);

      // R1 / R7: reference only, continuous events
      restart(0, 1, 1, 1);
      wait_ref(t0);
      check(t0 == 9, "R7 prescaler cleared, first ref edge", t0, 9);
      wait_ref(t1);
      check(t1 - t0 == 8, "R1 ref period", t1 - t0, 8);
      tick();
      check(pump_up && pump_oe && !pump_dn, "R4 up after ref edge", pump_up, 1);

      // R7: reset forces pump off without a clock edge
      rst = 1'b1;
      #1;
      check(!pump_oe && !pump_up, "R7 async off in reset", pump_oe, 0);
      rst = 1'b0;

      // R6: coincident edges
      ratio_code = 4'd0;
      restart(1, 1, 25, 25);
      repeat (900) tick();
      check(up_cnt == 0 && dn_cnt == 0, "R6 aligned edges no pump", up_cnt + dn_cnt, 0);

      // R9 / R4: reference leads by 3 cycles
      restart(1, 1, 22, 25);
      repeat (900) tick();
      check(up_cnt == 9, "R9 lead up cycles", up_cnt, 9);
      check(dn_cnt == 0, "R4 lead no dn", dn_cnt, 0);

      // R9 / R5: feedback leads by 3 cycles
      restart(1, 1, 28, 25);
      repeat (900) tick();
      check(dn_cnt == 9, "R9 lag dn cycles", dn_cnt, 9);
      check(up_cnt == 0, "R5 lag no up", up_cnt, 0);

      // R8: exclusivity over a mixed run
      begin
         int both = 0;
         restart(1, 1, 3, 7);
         for (int i = 0; i < 2000; i++) begin
            tick();
            if ((pump_up && pump_dn) || (pump_oe != (pump_up || pump_dn))) both++;
         end
         check(both == 0, "R8 outputs exclusive", both, 0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule